// File: doc/BRIEF.md
# Interleaved Slot Read-Bus Multiplexer

This block collects read data from modules placed in a row of equal-width resource slots and hands a static bus master one aligned word. The slots are spread across a set of independent multiplexer chains by position: slot `i` feeds chain `i mod NUM_CHAINS`, and each chain carries one byte lane. No single long chain runs past every slot, so each chain only merges the few slots that belong to it.

A module occupies a run of consecutive slots, described by a start slot and a width in slots. When its select is raised, only the slots inside its span drive their chains; every other slot contributes zero and the chains combine by OR. An alignment rotator then picks chain `(start + k) mod NUM_CHAINS` for output lane `k`. Byte 0 of the module therefore appears on lane 0 at any placement offset. Lane enables mark which lanes the module actually reaches, and lanes that are not enabled read as zero. The result is registered, so read data follows the inputs by exactly one clock.

Top module: `slot_read_bus`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rd_word` and `lane_en` become all zeros at that edge.
- R2: `rd_word` and `lane_en` change only at a rising clock edge and reflect the inputs sampled at that edge, which gives a read latency of one cycle.
- R3: Slot `i` (data bits `[i*LANE_W +: LANE_W]` of `slot_rdata`) feeds only chain `i mod NUM_CHAINS`.
- R4: A slot contributes data only when a module is selected and the slot lies in `[start, start+width)` of that module. With no select active, `rd_word` and `lane_en` are zero.
- R5: Output lane `k` (bits `[k*LANE_W +: LANE_W]` of `rd_word`) carries chain `(start + k) mod NUM_CHAINS`, so module byte 0 is always on lane 0.
- R6: `lane_en[k]` is 1 exactly when a module is selected, `k < width` and `start + k < NUM_SLOTS`. The enabled lanes always form a contiguous run starting at lane 0.
- R7: Any lane whose `lane_en` bit is 0 reads as zero in `rd_word`.
- R8: When several selects are active, the module with the lowest index sets the span and the alignment.
- R9: A module wider than `NUM_CHAINS` slots has several slots on one chain. That chain returns the bitwise OR of those slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_rdata | input | NUM_SLOTS*LANE_W | Read data offered by each slot, slot `i` at `[i*LANE_W +: LANE_W]` |
| mod_sel | input | NUM_MODS | Per-module read select, bit `m` for module `m` |
| mod_start | input | NUM_MODS*SLOT_IW | Start slot per module, module `m` at `[m*SLOT_IW +: SLOT_IW]` |
| mod_width | input | NUM_MODS*WID_W | Width in slots per module, module `m` at `[m*WID_W +: WID_W]` |
| rd_word | output | NUM_CHAINS*LANE_W | Registered, aligned read word |
| lane_en | output | NUM_CHAINS | Registered valid flag per output lane |

## Verification
The bench builds the block with its defaults: 8 slots, 4 chains, 8-bit lanes and 2 modules. Eight slots over four chains put exactly two slots on every chain. This makes the OR merge of a full-width module observable, and it lets a span that starts past slot 3 wrap the rotation. Start offsets near the top slot reach the clipped-lane case, where a module runs past the last slot. Two module selects are enough to exercise the lowest-index priority.

// File: rtl/rsb_pkg.sv
// Package: shared helpers for the interleaved slot read bus.
// Assumes callers pass non-negative slot indices, starts and widths.
package rsb_pkg;

    // True when slot idx lies in the half-open span [start, start+width).
    function automatic bit in_span(input int idx, input int start, input int width);
        return (idx >= start) && (idx < start + width);
    endfunction

    // Chain that a slot or a rotated lane position maps onto.
    function automatic int chain_of(input int pos, input int nchains);
        return pos % nchains;
    endfunction

endpackage

// File: rtl/rsb_mod_pick.sv
// Module: rsb_mod_pick
// Picks the active module from the per-module selects and forwards its
// start slot and width. The lowest selected index wins. Purely combinational.
// Assumes mod_start/mod_width are packed with module 0 in the low bits.
module rsb_mod_pick #(
    parameter int NUM_MODS = 2,
    parameter int SLOT_IW  = 3,
    parameter int WID_W    = 4
) (
    input  logic [NUM_MODS-1:0]         mod_sel,
    input  logic [NUM_MODS*SLOT_IW-1:0] mod_start,
    input  logic [NUM_MODS*WID_W-1:0]   mod_width,
    output logic                        pick_any,
    output logic [SLOT_IW-1:0]          pick_start,
    output logic [WID_W-1:0]            pick_width
);

    // Priority scan from the highest index down so the lowest selected index is kept last.
    always_comb begin
        pick_any   = 1'b0;
        pick_start = '0;
        pick_width = '0;
        for (int m = NUM_MODS - 1; m >= 0; m--) begin
            if (mod_sel[m]) begin
                pick_any   = 1'b1;
                pick_start = mod_start[m*SLOT_IW +: SLOT_IW];
                pick_width = mod_width[m*WID_W +: WID_W];
            end
        end
    end

endmodule

// File: rtl/rsb_slot_gate.sv
// Module: rsb_slot_gate
// Masks every slot's read data to zero unless a module is selected and the
// slot falls inside that module's span. One gate per slot, generated.
// Assumes slot i is packed at [i*LANE_W +: LANE_W].
module rsb_slot_gate #(
    parameter int NUM_SLOTS = 8,
    parameter int LANE_W    = 8,
    parameter int SLOT_IW   = 3,
    parameter int WID_W     = 4
) (
    input  logic [NUM_SLOTS*LANE_W-1:0] slot_rdata,
    input  logic                        pick_any,
    input  logic [SLOT_IW-1:0]          pick_start,
    input  logic [WID_W-1:0]            pick_width,
    output logic [NUM_SLOTS*LANE_W-1:0] slot_gated
);

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
        logic live;

        // Decide whether this slot belongs to the active module's span.
        always_comb live = pick_any &&
            rsb_pkg::in_span(gi, int'(pick_start), int'(pick_width));

        // Pass the slot's data or force zero onto its chain.
        always_comb slot_gated[gi*LANE_W +: LANE_W] =
            live ? slot_rdata[gi*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/rsb_chain_or.sv
// Module: rsb_chain_or
// Builds the interleaved chains: chain c merges by OR every slot whose
// index is congruent to c modulo NUM_CHAINS. Depth grows with
// NUM_SLOTS/NUM_CHAINS, not with NUM_SLOTS.
// Assumes inactive slots already present zero.
module rsb_chain_or #(
    parameter int NUM_SLOTS  = 8,
    parameter int NUM_CHAINS = 4,
    parameter int LANE_W     = 8
) (
    input  logic [NUM_SLOTS*LANE_W-1:0]  slot_gated,
    output logic [NUM_CHAINS*LANE_W-1:0] chain_out
);

    for (genvar gc = 0; gc < NUM_CHAINS; gc++) begin : g_chain
        logic [LANE_W-1:0] acc;

        // OR together the slots that belong to this chain.
        always_comb begin
            acc = '0;
            for (int j = gc; j < NUM_SLOTS; j += NUM_CHAINS) begin
                acc = acc | slot_gated[j*LANE_W +: LANE_W];
            end
        end

        // Publish the chain end.
        always_comb chain_out[gc*LANE_W +: LANE_W] = acc;
    end

endmodule

// File: rtl/rsb_lane_align.sv
// Module: rsb_lane_align
// Rotates the chain ends so module byte k lands on output lane k, and
// derives the per-lane valid flags. A lane is valid when it is within the
// module width and does not run past the last slot. Invalid lanes read zero.
// Assumes chain c is packed at [c*LANE_W +: LANE_W].
module rsb_lane_align #(
    parameter int NUM_SLOTS  = 8,
    parameter int NUM_CHAINS = 4,
    parameter int LANE_W     = 8,
    parameter int SLOT_IW    = 3,
    parameter int WID_W      = 4
) (
    input  logic [NUM_CHAINS*LANE_W-1:0] chain_out,
    input  logic                         pick_any,
    input  logic [SLOT_IW-1:0]           pick_start,
    input  logic [WID_W-1:0]             pick_width,
    output logic [NUM_CHAINS*LANE_W-1:0] word_comb,
    output logic [NUM_CHAINS-1:0]        en_comb
);

    for (genvar gk = 0; gk < NUM_CHAINS; gk++) begin : g_lane
        int pos;
        int src;

        // Slot position of module byte gk and the chain that carries it.
        always_comb begin
            pos = int'(pick_start) + gk;
            src = rsb_pkg::chain_of(pos, NUM_CHAINS);
        end

        // Lane valid: selected, inside the width, inside the slot row.
        always_comb en_comb[gk] = pick_any && (gk < int'(pick_width)) && (pos < NUM_SLOTS);

        // Select the rotated chain, or zero for an invalid lane.
        always_comb word_comb[gk*LANE_W +: LANE_W] =
            en_comb[gk] ? chain_out[src*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/slot_read_bus.sv
// Module: slot_read_bus (top)
// Read-side bus for modules placed in a row of resource slots. It picks the
// selected module, gates the slots outside its span, merges slots into
// NUM_CHAINS interleaved chains, and rotates the chain ends into lane order.
// The aligned word and lane flags are registered (one-cycle latency).
// Assumes the slot data is already synchronous to clk.
module slot_read_bus #(
    parameter int NUM_SLOTS  = 8,
    parameter int NUM_CHAINS = 4,
    parameter int LANE_W     = 8,
    parameter int NUM_MODS   = 2,
    parameter int SLOT_IW    = $clog2(NUM_SLOTS),
    parameter int WID_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SLOTS*LANE_W-1:0]  slot_rdata,
    input  logic [NUM_MODS-1:0]          mod_sel,
    input  logic [NUM_MODS*SLOT_IW-1:0]  mod_start,
    input  logic [NUM_MODS*WID_W-1:0]    mod_width,
    output logic [NUM_CHAINS*LANE_W-1:0] rd_word,
    output logic [NUM_CHAINS-1:0]        lane_en
);

    localparam int WORD_W = NUM_CHAINS * LANE_W;
    localparam int DATA_W = NUM_SLOTS * LANE_W;

    logic                pick_any;
    logic [SLOT_IW-1:0]  pick_start;
    logic [WID_W-1:0]    pick_width;
    logic [DATA_W-1:0]   slot_gated;
    logic [WORD_W-1:0]   chain_out;
    logic [WORD_W-1:0]   word_comb;
    logic [NUM_CHAINS-1:0] en_comb;

    rsb_mod_pick #(
        .NUM_MODS (NUM_MODS),
        .SLOT_IW  (SLOT_IW),
        .WID_W    (WID_W)
    ) u_pick (
        .mod_sel    (mod_sel),
        .mod_start  (mod_start),
        .mod_width  (mod_width),
        .pick_any   (pick_any),
        .pick_start (pick_start),
        .pick_width (pick_width)
    );

    rsb_slot_gate #(
        .NUM_SLOTS (NUM_SLOTS),
        .LANE_W    (LANE_W),
        .SLOT_IW   (SLOT_IW),
        .WID_W     (WID_W)
    ) u_gate (
        .slot_rdata (slot_rdata),
        .pick_any   (pick_any),
        .pick_start (pick_start),
        .pick_width (pick_width),
        .slot_gated (slot_gated)
    );

    rsb_chain_or #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_CHAINS (NUM_CHAINS),
        .LANE_W     (LANE_W)
    ) u_chains (
        .slot_gated (slot_gated),
        .chain_out  (chain_out)
    );

    rsb_lane_align #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_CHAINS (NUM_CHAINS),
        .LANE_W     (LANE_W),
        .SLOT_IW    (SLOT_IW),
        .WID_W      (WID_W)
    ) u_align (
        .chain_out  (chain_out),
        .pick_any   (pick_any),
        .pick_start (pick_start),
        .pick_width (pick_width),
        .word_comb  (word_comb),
        .en_comb    (en_comb)
    );

    // Output register: fixed one-cycle read latency, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
            lane_en <= '0;
        end else begin
            rd_word <= word_comb;
            lane_en <= en_comb;
        end
    end

endmodule

// File: rtl/slot_read_bus_chk.sv
// Module: slot_read_bus_chk
// Port-level checks for slot_read_bus, attached with bind below.
module slot_read_bus_chk #(
    parameter int NUM_SLOTS  = 8,
    parameter int NUM_CHAINS = 4,
    parameter int LANE_W     = 8,
    parameter int NUM_MODS   = 2,
    parameter int SLOT_IW    = 3,
    parameter int WID_W      = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_SLOTS*LANE_W-1:0]  slot_rdata,
    input logic [NUM_MODS-1:0]          mod_sel,
    input logic [NUM_MODS*SLOT_IW-1:0]  mod_start,
    input logic [NUM_MODS*WID_W-1:0]    mod_width,
    input logic [NUM_CHAINS*LANE_W-1:0] rd_word,
    input logic [NUM_CHAINS-1:0]        lane_en
);

    // R1: a reset edge leaves both outputs cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_word == '0 && lane_en == '0));

    // R2: inputs held across an edge give held outputs one cycle later.
    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(slot_rdata) && $stable(mod_sel) &&
         $stable(mod_start) && $stable(mod_width))
        |=> ($stable(rd_word) && $stable(lane_en)));

    // R4: no select gives an idle word next cycle.
    p_no_sel_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel == '0) |=> (rd_word == '0 && lane_en == '0));

    // R6: valid lanes are a contiguous run from lane 0.
    p_lane_thermo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_en & (lane_en + NUM_CHAINS'(1))) == '0));

    // R7: a disabled lane reads zero.
    for (genvar gk = 0; gk < NUM_CHAINS; gk++) begin : g_lane_chk
        p_off_lane_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_en[gk] |-> (rd_word[gk*LANE_W +: LANE_W] == '0));
    end

endmodule

bind slot_read_bus slot_read_bus_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_CHAINS (NUM_CHAINS),
    .LANE_W     (LANE_W),
    .NUM_MODS   (NUM_MODS),
    .SLOT_IW    (SLOT_IW),
    .WID_W      (WID_W)
) u_chk (.*);

// File: tb/slot_read_bus_bench.sv
// Directed bench for slot_read_bus: one task per scenario.
module slot_read_bus_bench;

    localparam int NS = 8;
    localparam int NC = 4;
    localparam int LW = 8;
    localparam int NM = 2;
    localparam int SIW = 3;
    localparam int WW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS*LW-1:0]  slot_rdata = '0;
    logic [NM-1:0]     mod_sel = '0;
    logic [NM*SIW-1:0] mod_start = '0;
    logic [NM*WW-1:0]  mod_width = '0;
    logic [NC*LW-1:0]  rd_word;
    logic [NC-1:0]     lane_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    slot_read_bus u_slot_read_bus (
        .clk(clk), .rst_n(rst_n), .slot_rdata(slot_rdata), .mod_sel(mod_sel),
        .mod_start(mod_start), .mod_width(mod_width),
        .rd_word(rd_word), .lane_en(lane_en)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Independent model from the requirements text.
    task automatic model(output logic [NC*LW-1:0] w, output logic [NC-1:0] e);
        int s = 0;
        int wd = 0;
        bit any = 1'b0;
        w = '0;
        e = '0;
        for (int m = 0; m < NM; m++) begin
            if (mod_sel[m] && !any) begin
                any = 1'b1;
                s = int'(mod_start[m*SIW +: SIW]);
                wd = int'(mod_width[m*WW +: WW]);
            end
        end
        for (int k = 0; k < NC; k++) begin
            if (any && k < wd && s + k < NS) begin
                e[k] = 1'b1;
                for (int j = s; j < s + wd && j < NS; j++) begin
                    if (j % NC == (s + k) % NC)
                        w[k*LW +: LW] = w[k*LW +: LW] | slot_rdata[j*LW +: LW];
                end
            end
        end
    endtask

    task automatic set_mod(int m, int st, int wd);
        mod_start[m*SIW +: SIW] = SIW'(st);
        mod_width[m*WW +: WW] = WW'(wd);
    endtask

    task automatic fill_slots(logic [7:0] base);
        for (int i = 0; i < NS; i++) slot_rdata[i*LW +: LW] = base + 8'(i);
    endtask

    // Drive at the falling edge, sample just after the next rising edge.
    task automatic step_check(string req, logic [NC*LW-1:0] ew, logic [NC-1:0] ee);
        @(posedge clk);
        #1;
        check(req, "rd_word", 64'(rd_word), 64'(ew));
        check(req, "lane_en", 64'(lane_en), 64'(ee));
    endtask

    task automatic step_model(string req);
        logic [NC*LW-1:0] ew;
        logic [NC-1:0] ee;
        model(ew, ee);
        step_check(req, ew, ee);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        fill_slots(8'h10);
        set_mod(0, 0, 4);
        mod_sel = 2'b01;
        step_check("R1", '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_aligned;
        @(negedge clk);
        fill_slots(8'h10);
        mod_sel = 2'b01;
        set_mod(0, 0, 4);
        step_check("R3", 32'h13121110, 4'b1111);
    endtask

    task automatic t_offset;
        @(negedge clk);
        fill_slots(8'h20);
        mod_sel = 2'b01;
        set_mod(0, 3, 4);
        step_check("R5", 32'h26252423, 4'b1111);
        @(negedge clk);
        set_mod(0, 5, 3);
        step_model("R5");
    endtask

    task automatic t_narrow;
        @(negedge clk);
        fill_slots(8'h40);
        mod_sel = 2'b01;
        set_mod(0, 5, 1);
        step_check("R7", 32'h00000045, 4'b0001);
    endtask

    task automatic t_clip;
        @(negedge clk);
        fill_slots(8'h50);
        mod_sel = 2'b01;
        set_mod(0, 6, 4);
        step_check("R6", 32'h00005756, 4'b0011);
    endtask

    task automatic t_wide;
        @(negedge clk);
        for (int i = 0; i < NS; i++) slot_rdata[i*LW +: LW] = 8'(1 << i);
        mod_sel = 2'b01;
        set_mod(0, 0, 8);
        step_check("R9", 32'h88442211, 4'b1111);
        @(negedge clk);
        set_mod(0, 2, 6);
        step_model("R9");
    endtask

    task automatic t_none;
        @(negedge clk);
        fill_slots(8'h60);
        mod_sel = 2'b00;
        set_mod(0, 0, 4);
        step_check("R4", '0, '0);
        @(negedge clk);
        mod_sel = 2'b01;
        set_mod(0, 4, 2);
        step_check("R4", 32'h00006564, 4'b0011);
    endtask

    task automatic t_priority;
        @(negedge clk);
        fill_slots(8'h70);
        set_mod(0, 2, 2);
        set_mod(1, 4, 4);
        mod_sel = 2'b11;
        step_check("R8", 32'h00007372, 4'b0011);
        @(negedge clk);
        mod_sel = 2'b10;
        step_check("R8", 32'h77767574, 4'b1111);
    endtask

    task automatic t_latency;
        @(negedge clk);
        fill_slots(8'h80);
        mod_sel = 2'b01;
        set_mod(0, 0, 4);
        step_check("R2", 32'h83828180, 4'b1111);
        @(negedge clk);
        set_mod(0, 1, 2);
        #1;
        check("R2", "rd_word held", 64'(rd_word), 64'h83828180);
        step_check("R2", 32'h00008281, 4'b0011);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_aligned();
        t_offset();
        t_narrow();
        t_clip();
        t_wide();
        t_none();
        t_priority();
        t_latency();
        t_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule